// File: doc/BRIEF.md
# Link Fragment Formatter with Spy Capture

The block turns a stream of event words into one framed fragment for a downstream serial link. A fragment opens with a start control word, then a header carrying an 8-bit bunch number, then the event words, then a trailer carrying the count of event words, and it closes with an end control word. Upstream words arrive on a valid/ready pair, and the last word of an event is flagged. The link's full and down signals stall the output without losing or reordering any word. A user reset input abandons any fragment in progress.

On request, the block emits a fragment with no event words: start, header, trailer with a count of zero, and end. This keeps the link alive when the upstream source is unavailable. Every word that leaves the block can also be copied into a small spy FIFO, together with its control flag and the formatter state code that produced it. A host reads this FIFO one entry at a time and can switch capture on and off. When the FIFO is full, further words are not stored and a sticky overflow flag is raised.

The controller has six states:
- `ST_IDLE` (0): waiting for work.
- `ST_BOF` (1): sending the start control word.
- `ST_HDR` (2): sending the header.
- `ST_DATA` (3): passing event words through.
- `ST_TRL` (4): sending the trailer.
- `ST_EOF` (5): sending the end control word.

Transitions:
- IDLE→BOF on an empty request or on upstream valid.
- BOF→HDR when its word is sent.
- HDR→DATA when the header is sent, or HDR→TRL for an empty fragment.
- DATA→TRL when the flagged last word is sent.
- TRL→EOF when the trailer is sent.
- EOF→IDLE when the end word is sent.
- Any state→IDLE on user reset.

Top module: `frag_formatter`

## Requirements
- R1: Each fragment leaves on `lnk_data` in this order: start word 0xB0F00000 with `lnk_ctrl`=1, header, event words, trailer, end word 0xE0F00000 with `lnk_ctrl`=1. `lnk_ctrl` is 0 on the header, event and trailer words. No other words are sent.
- R2: The header is {24'h484452, bunch}. Bunch is the value of `bunch_cnt` in the last cycle before the fragment leaves IDLE; later changes to `bunch_cnt` do not alter it.
- R3: The trailer is {16'h5452, N}, where N is the number of event words sent in that fragment.
- R4: No word is sent (`lnk_we`=1) in a cycle with `lnk_full` or `lnk_down` high. Stalls neither drop nor reorder words.
- R5: While `usr_rst` is high nothing is sent, and the formatter returns to IDLE with the partial fragment dropped. The next fragment's count starts from zero.
- R6: An `empty_req` seen in IDLE produces start, header, trailer with N=0, and end. It takes priority over upstream data waiting in the same cycle. `empty_req` has no effect outside IDLE.
- R7: With `spy_en` high, each sent word is stored in the spy FIFO as data, control flag and state code (IDLE=0, BOF=1, HDR=2, DATA=3, TRL=4, EOF=5). The oldest entry is shown on `spy_rdata`/`spy_rctrl`/`spy_rstate` while `spy_empty` is 0, and `spy_rd` pops it.
- R8: With `spy_en` low, sent words are not stored.
- R9: A word that arrives for capture while the spy FIFO holds SPY_DEPTH entries is discarded. `spy_ovf` then rises and stays high until `rst_n`.
- R10: `in_ready` is high only in the DATA state when the link may accept a word. After each end word the formatter spends one idle cycle before it can send again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| usr_rst | input | 1 | Synchronous user reset: drop the fragment and go idle |
| in_valid | input | 1 | Upstream word valid |
| in_data | input | DW | Upstream event word |
| in_last | input | 1 | Marks the final event word of a fragment |
| in_ready | output | 1 | Upstream word accepted this cycle when valid |
| empty_req | input | 1 | Request an empty fragment |
| bunch_cnt | input | BCW | Bunch number for the header |
| lnk_full | input | 1 | Downstream link cannot take a word |
| lnk_down | input | 1 | Downstream link not operational |
| lnk_we | output | 1 | Word presented to the link this cycle |
| lnk_data | output | DW | Outgoing word |
| lnk_ctrl | output | 1 | Control-word flag for the outgoing word |
| spy_en | input | 1 | Spy capture enable |
| spy_rd | input | 1 | Pop the oldest spy entry |
| spy_rdata | output | DW | Oldest spy entry: word |
| spy_rctrl | output | 1 | Oldest spy entry: control flag |
| spy_rstate | output | 3 | Oldest spy entry: state code |
| spy_empty | output | 1 | Spy FIFO holds no entry |
| spy_ovf | output | 1 | Sticky spy overflow flag |

## Verification
Link outputs are combinational from the state register and the upstream word, so a word is due in the same cycle its state is reached, and an event word is due in the cycle it is offered while `in_ready` is high. The bunch number is latched at the edge that leaves IDLE. The trailer count reflects every event word committed at earlier edges. A spy entry, a pop and the overflow flag all become visible one cycle after the edge that commits them. The bench drives inputs on the falling edge and samples 2 ns before the rising edge, which is when the link word and flags for that edge are final. It folds each committed edge into its model only after comparing, so every result is compared in the cycle it is due.

// File: rtl/frag_pkg.sv
package frag_pkg;
    localparam int ST_W = 3;

    typedef enum logic [ST_W-1:0] {
        ST_IDLE = 3'd0,
        ST_BOF  = 3'd1,
        ST_HDR  = 3'd2,
        ST_DATA = 3'd3,
        ST_TRL  = 3'd4,
        ST_EOF  = 3'd5
    } frag_st_e;
endpackage

// File: rtl/frag_fsm.sv
module frag_fsm
    import frag_pkg::*;
#(
    parameter int DW   = 32,
    parameter int BCW  = 8,
    parameter int CNTW = 16,
    parameter logic [DW-1:0]      BOF_CODE = DW'(32'hB0F0_0000),
    parameter logic [DW-1:0]      EOF_CODE = DW'(32'hE0F0_0000),
    parameter logic [DW-BCW-1:0]  HDR_TAG  = (DW-BCW)'(24'h48_4452),
    parameter logic [DW-CNTW-1:0] TRL_TAG  = (DW-CNTW)'(16'h5452)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           usr_rst,
    input  logic           in_valid,
    input  logic [DW-1:0]  in_data,
    input  logic           in_last,
    output logic           in_ready,
    input  logic           empty_req,
    input  logic [BCW-1:0] bunch_cnt,
    input  logic           lnk_full,
    input  logic           lnk_down,
    output logic           lnk_we,
    output logic [DW-1:0]  lnk_data,
    output logic           lnk_ctrl,
    output frag_st_e       st_o
);
    frag_st_e        st, nxt;
    logic [BCW-1:0]  bc_q;
    logic [CNTW-1:0] cnt_q;
    logic            empty_q;
    logic            link_ok;
    logic            fire;

    assign link_ok = !lnk_full && !lnk_down && !usr_rst;
    assign fire    = (st != ST_IDLE) && link_ok && ((st != ST_DATA) || in_valid);
    assign st_o    = st;

    // state register with the fragment bookkeeping it owns
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            bc_q    <= '0;
            cnt_q   <= '0;
            empty_q <= 1'b0;
        end else if (usr_rst) begin
            st      <= ST_IDLE;
            cnt_q   <= '0;
            empty_q <= 1'b0;
        end else begin
            st <= nxt;
            if (st == ST_IDLE) begin
                bc_q    <= bunch_cnt;
                cnt_q   <= '0;
                empty_q <= empty_req;
            end else if (st == ST_DATA && fire) begin
                cnt_q <= cnt_q + CNTW'(1);
            end
        end
    end

    // transitions
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: if (empty_req || in_valid) nxt = ST_BOF;
            ST_BOF:  if (fire) nxt = ST_HDR;
            ST_HDR:  if (fire) nxt = empty_q ? ST_TRL : ST_DATA;
            ST_DATA: if (fire && in_last) nxt = ST_TRL;
            ST_TRL:  if (fire) nxt = ST_EOF;
            ST_EOF:  if (fire) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        lnk_we   = fire;
        in_ready = (st == ST_DATA) && link_ok;
        lnk_ctrl = 1'b0;
        lnk_data = '0;
        unique case (st)
            ST_IDLE: lnk_data = '0;
            ST_BOF:  begin lnk_data = BOF_CODE; lnk_ctrl = 1'b1; end
            ST_HDR:  lnk_data = {HDR_TAG, bc_q};
            ST_DATA: lnk_data = in_data;
            ST_TRL:  lnk_data = {TRL_TAG, cnt_q};
            ST_EOF:  begin lnk_data = EOF_CODE; lnk_ctrl = 1'b1; end
            default: lnk_data = '0;
        endcase
    end
endmodule

// File: rtl/frag_spy_fifo.sv
module frag_spy_fifo #(
    parameter int W     = 36,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         ovf
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp, rp;
    logic         full;

    assign empty   = (wp == rp);
    assign full    = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
    assign rd_data = mem[rp[AW-1:0]];

    always_ff @(posedge clk) begin
        if (wr_en && !full) mem[wp[AW-1:0]] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            ovf <= 1'b0;
        end else begin
            if (wr_en && !full) wp <= wp + 1'b1;
            if (wr_en && full)  ovf <= 1'b1;
            if (rd_en && !empty) rp <= rp + 1'b1;
        end
    end
endmodule

// File: rtl/frag_formatter.sv
module frag_formatter
    import frag_pkg::*;
#(
    parameter int DW        = 32,
    parameter int BCW       = 8,
    parameter int CNTW      = 16,
    parameter int SPY_DEPTH = 16,
    parameter logic [DW-1:0]      BOF_CODE = DW'(32'hB0F0_0000),
    parameter logic [DW-1:0]      EOF_CODE = DW'(32'hE0F0_0000),
    parameter logic [DW-BCW-1:0]  HDR_TAG  = (DW-BCW)'(24'h48_4452),
    parameter logic [DW-CNTW-1:0] TRL_TAG  = (DW-CNTW)'(16'h5452)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           usr_rst,
    input  logic           in_valid,
    input  logic [DW-1:0]  in_data,
    input  logic           in_last,
    output logic           in_ready,
    input  logic           empty_req,
    input  logic [BCW-1:0] bunch_cnt,
    input  logic           lnk_full,
    input  logic           lnk_down,
    output logic           lnk_we,
    output logic [DW-1:0]  lnk_data,
    output logic           lnk_ctrl,
    input  logic           spy_en,
    input  logic           spy_rd,
    output logic [DW-1:0]  spy_rdata,
    output logic           spy_rctrl,
    output logic [2:0]     spy_rstate,
    output logic           spy_empty,
    output logic           spy_ovf
);
    localparam int SPY_W = ST_W + 1 + DW;

    frag_st_e         st;
    logic [SPY_W-1:0] spy_wdata, spy_head;

    frag_fsm #(
        .DW(DW), .BCW(BCW), .CNTW(CNTW),
        .BOF_CODE(BOF_CODE), .EOF_CODE(EOF_CODE),
        .HDR_TAG(HDR_TAG), .TRL_TAG(TRL_TAG)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .usr_rst(usr_rst),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_ready(in_ready), .empty_req(empty_req), .bunch_cnt(bunch_cnt),
        .lnk_full(lnk_full), .lnk_down(lnk_down),
        .lnk_we(lnk_we), .lnk_data(lnk_data), .lnk_ctrl(lnk_ctrl),
        .st_o(st)
    );

    assign spy_wdata = {st, lnk_ctrl, lnk_data};

    frag_spy_fifo #(.W(SPY_W), .DEPTH(SPY_DEPTH)) u_spy (
        .clk(clk), .rst_n(rst_n),
        .wr_en(lnk_we && spy_en), .wr_data(spy_wdata),
        .rd_en(spy_rd), .rd_data(spy_head),
        .empty(spy_empty), .ovf(spy_ovf)
    );

    assign spy_rstate = spy_head[SPY_W-1 -: ST_W];
    assign spy_rctrl  = spy_head[DW];
    assign spy_rdata  = spy_head[DW-1:0];
endmodule

// File: rtl/frag_formatter_chk.sv
module frag_formatter_chk
    import frag_pkg::*;
#(
    parameter int DW = 32,
    parameter logic [DW-1:0] EOF_CODE = DW'(32'hE0F0_0000)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          usr_rst,
    input logic          lnk_full,
    input logic          lnk_down,
    input logic          lnk_we,
    input logic          lnk_ctrl,
    input logic [DW-1:0] lnk_data,
    input frag_st_e      st,
    input logic          spy_en,
    input logic          spy_rd,
    input logic          spy_empty,
    input logic          spy_ovf
);
    a_r4_no_send_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        lnk_we |-> (!lnk_full && !lnk_down));

    a_r5_user_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        usr_rst |=> !lnk_we);

    a_r10_gap_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_we && lnk_ctrl && lnk_data == EOF_CODE) |=> !lnk_we);

    a_r4_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && !lnk_we && !usr_rst) |=> $stable(st));

    a_r8_no_capture_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!spy_en && !spy_rd) |=> $stable(spy_empty));

    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        spy_ovf |=> spy_ovf);
endmodule

bind frag_formatter frag_formatter_chk #(.DW(DW), .EOF_CODE(EOF_CODE)) u_chk (
    .clk(clk), .rst_n(rst_n), .usr_rst(usr_rst),
    .lnk_full(lnk_full), .lnk_down(lnk_down),
    .lnk_we(lnk_we), .lnk_ctrl(lnk_ctrl), .lnk_data(lnk_data),
    .st(st), .spy_en(spy_en), .spy_rd(spy_rd),
    .spy_empty(spy_empty), .spy_ovf(spy_ovf)
);

// File: tb/tb_frag_formatter.sv
`timescale 1ns/1ps
module tb_frag_formatter;
    localparam int SPY_D = 16;
    localparam logic [31:0] BOFW = 32'hB0F0_0000;
    localparam logic [31:0] EOFW = 32'hE0F0_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic usr_rst = 1'b0, in_valid = 1'b0, in_last = 1'b0, empty_req = 1'b0;
    logic [31:0] in_data = '0;
    logic [7:0]  bunch_cnt = '0;
    logic lnk_full = 1'b0, lnk_down = 1'b0, spy_en = 1'b1, spy_rd = 1'b0;
    logic in_ready, lnk_we, lnk_ctrl, spy_rctrl, spy_empty, spy_ovf;
    logic [31:0] lnk_data, spy_rdata;
    logic [2:0]  spy_rstate;

    always #4 clk = ~clk;

    frag_formatter dut (
        .clk(clk), .rst_n(rst_n), .usr_rst(usr_rst),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .empty_req(empty_req), .bunch_cnt(bunch_cnt),
        .lnk_full(lnk_full), .lnk_down(lnk_down),
        .lnk_we(lnk_we), .lnk_data(lnk_data), .lnk_ctrl(lnk_ctrl),
        .spy_en(spy_en), .spy_rd(spy_rd), .spy_rdata(spy_rdata), .spy_rctrl(spy_rctrl),
        .spy_rstate(spy_rstate), .spy_empty(spy_empty), .spy_ovf(spy_ovf)
    );

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0, mon_on = 1'b0;

    // reference model: expected link words and spy contents
    logic [31:0] ed[$];
    logic        ec[$];
    logic [2:0]  es[$];
    string       et[$];
    logic [35:0] sq[$];
    logic        ovf_m = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_word(input logic [31:0] d, input logic c, input logic [2:0] s, input string t);
        ed.push_back(d); ec.push_back(c); es.push_back(s); et.push_back(t);
    endtask

    task automatic expect_empty(input logic [7:0] bc);
        expect_word(BOFW, 1'b1, 3'd1, "R6 empty start");
        expect_word({24'h484452, bc}, 1'b0, 3'd2, "R6 empty header");
        expect_word({16'h5452, 16'd0}, 1'b0, 3'd4, "R6 empty trailer");
        expect_word(EOFW, 1'b1, 3'd5, "R6 empty end");
    endtask

    // monitor: compares every clock, 2 ns before the rising edge
    logic        full_pre;
    logic [35:0] entry;
    always begin
        @(negedge clk); #2;
        if (rst_n && mon_on) begin
            chk(spy_empty == (sq.size() == 0), "R7 spy_empty", 64'(spy_empty), 64'(sq.size() == 0));
            chk(spy_ovf == ovf_m, "R9 spy_ovf", 64'(spy_ovf), 64'(ovf_m));
            full_pre = (sq.size() >= SPY_D);
            if (spy_rd && sq.size() > 0) begin
                chk({spy_rstate, spy_rctrl, spy_rdata} == sq[0], "R7 spy entry",
                    64'({spy_rstate, spy_rctrl, spy_rdata}), 64'(sq[0]));
                void'(sq.pop_front());
            end
            if (lnk_we) begin
                chk(!lnk_full && !lnk_down, "R4 word sent while blocked",
                    64'({lnk_full, lnk_down}), 64'(0));
                if (ed.size() == 0) begin
                    chk(1'b0, "R1 unexpected word", 64'({lnk_ctrl, lnk_data}), 64'(0));
                    entry = {3'd0, lnk_ctrl, lnk_data};
                end else begin
                    chk(lnk_data == ed[0] && lnk_ctrl == ec[0], et[0],
                        64'({lnk_ctrl, lnk_data}), 64'({ec[0], ed[0]}));
                    entry = {es[0], ec[0], ed[0]};
                    void'(ed.pop_front()); void'(ec.pop_front());
                    void'(es.pop_front()); void'(et.pop_front());
                end
                if (spy_en) begin
                    if (!full_pre) sq.push_back(entry);
                    else ovf_m = 1'b1;
                end
            end
        end
    end

    task automatic send_frag(input int n, input logic [7:0] bc, input logic [31:0] base,
                             input bit term, input bit with_empty);
        bit ok;
        if (with_empty) expect_empty(bc);
        expect_word(BOFW, 1'b1, 3'd1, "R1 start word");
        expect_word({24'h484452, bc}, 1'b0, 3'd2, "R2 header");
        for (int i = 0; i < n; i++) expect_word(base + i, 1'b0, 3'd3, "R1 event word");
        if (term) begin
            expect_word({16'h5452, 16'(n)}, 1'b0, 3'd4, "R3 trailer");
            expect_word(EOFW, 1'b1, 3'd5, "R1 end word");
        end
        @(negedge clk);
        bunch_cnt = bc;
        if (with_empty) empty_req = 1'b1;
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1;
            in_data  = base + i;
            in_last  = term && (i == n - 1);
            forever begin
                #2 ok = in_ready;
                @(negedge clk);
                empty_req = 1'b0;
                if (ok) break;
            end
            if (i == 0) bunch_cnt = ~bc;
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic drain();
        @(negedge clk) spy_rd = 1'b1;
        repeat (SPY_D + 4) @(negedge clk);
        spy_rd = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk(!lnk_we && !in_ready, "R10 reset outputs", 64'({lnk_we, in_ready}), 64'(0));
        chk(spy_empty && !spy_ovf, "R7 reset spy", 64'({spy_empty, spy_ovf}), 64'(2'b10));
        mon_on = 1'b1;

        // plain fragments of different lengths (R1 R2 R3)
        send_frag(3, 8'h5A, 32'h1000_0000, 1'b1, 1'b0);
        repeat (4) @(negedge clk);
        send_frag(1, 8'hC3, 32'h2000_0000, 1'b1, 1'b0);
        repeat (4) @(negedge clk);
        drain();

        // empty request in idle (R6)
        expect_empty(8'h77);
        @(negedge clk); bunch_cnt = 8'h77; empty_req = 1'b1;
        @(negedge clk); empty_req = 1'b0; bunch_cnt = 8'h00;
        repeat (8) @(negedge clk);
        drain();

        // empty request together with waiting data: empty first (R6)
        send_frag(2, 8'h3C, 32'h3000_0000, 1'b1, 1'b1);
        repeat (6) @(negedge clk);
        drain();

        // empty request while busy is ignored (R6)
        fork
            send_frag(6, 8'h11, 32'h4000_0000, 1'b1, 1'b0);
            begin
                repeat (5) @(negedge clk);
                empty_req = 1'b1;
                @(negedge clk);
                empty_req = 1'b0;
            end
        join
        repeat (8) @(negedge clk);
        chk(ed.size() == 0, "R6 busy request ignored", 64'(ed.size()), 64'(0));
        drain();

        // link full / down stalls (R4)
        fork
            send_frag(8, 8'h99, 32'h5000_0000, 1'b1, 1'b0);
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                lnk_full = (i % 3 == 1);
                lnk_down = (i % 7 == 3);
            end
        join
        @(negedge clk); lnk_full = 1'b0; lnk_down = 1'b0;
        repeat (8) @(negedge clk);
        drain();

        // user reset mid fragment (R5)
        send_frag(2, 8'h42, 32'h6000_0000, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        usr_rst = 1'b1;
        @(negedge clk); usr_rst = 1'b0;
        repeat (4) @(negedge clk);
        chk(!lnk_we, "R5 idle after user reset", 64'(lnk_we), 64'(0));
        send_frag(3, 8'h43, 32'h6100_0000, 1'b1, 1'b0);
        repeat (6) @(negedge clk);
        drain();

        // capture disabled (R8)
        @(negedge clk) spy_en = 1'b0;
        send_frag(2, 8'h21, 32'h7000_0000, 1'b1, 1'b0);
        repeat (6) @(negedge clk);
        #2 chk(spy_empty, "R8 nothing captured when disabled", 64'(spy_empty), 64'(1));
        @(negedge clk) spy_en = 1'b1;

        // overflow: 18 words into 16 entries (R9)
        send_frag(14, 8'hE1, 32'h8000_0000, 1'b1, 1'b0);
        repeat (6) @(negedge clk);
        #2 chk(spy_ovf, "R9 overflow raised", 64'(spy_ovf), 64'(1));
        drain();
        repeat (3) @(negedge clk);
        #2 chk(spy_ovf, "R9 overflow sticky", 64'(spy_ovf), 64'(1));

        chk(ed.size() == 0, "R1 all expected words sent", 64'(ed.size()), 64'(0));
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule